// File: doc/BRIEF.md
# Sliding Window Scan Address Generator

This block produces a two-dimensional stream of addresses for a data-stream engine that reads memory in scan order instead of by instruction fetch. It is made of three copies of one stepper circuit. Each stepper holds a register, adds a signed step vector to it, compares the result with a stop value, and counts its steps against a programmable budget. The address stepper walks one line of the scan. The base slider moves the start of each line, and the limit slider moves the end of each line. The bounds of each line move independently between lines, so plain video scans, mirrored scans, sheared scans and non-rectangular scans all use the same logic.

Software sets the configuration inputs and pulses `start` while the block is idle. The addresses then leave on a valid/ready stream. An address is accepted in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered address is held and nothing inside the block moves. The block drives `out_last` together with the final address. After that address is accepted the block goes idle and waits for the next `start`. The configuration inputs must stay stable for the whole scan.

Every address and vector has two 8-bit fields: x in bits 7:0 and y in bits 15:8. Each field of a step vector is a two's-complement value. Field arithmetic wraps modulo 256.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset `out_valid` and `out_last` are low. A `start` seen while idle makes `out_valid` rise on the next cycle, and the first address offered equals `base_init`.
- R2: Within a line, each accepted address is followed by that address plus `addr_step`. The addition is done per field, modulo 256, with x in bits 7:0 and y in bits 15:8, and a step field of 8'hFF means minus one.
- R3: The limit test is inclusive. An address equal to the current line limit is still emitted, and the next address begins a new line.
- R4: If the limit is never met, a line ends after `addr_max`+1 addresses.
- R5: At the end of a line that is not the final one, the base moves by `base_step` and the next line starts at the new base. The limit moves by `lim_step` unless R6 holds it.
- R6: The limit slider stops moving once it has taken `lim_max` steps, or once its value equals `lim_stop`. From then on, later lines use the held limit.
- R7: The final line is a line that starts while the base slider has taken `base_max` steps or while the base equals `base_stop`. `out_last` is high only together with that line's last address. After that address is accepted, `out_valid` is low on the next cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_last` are held, and the accepted sequence is the same as with `out_ready` held high.
- R9: A `start` pulse while a scan is running is ignored, and the sequence continues unchanged.
- R10: With all step vectors zero and all maximum counts zero, exactly one address is emitted, and it carries `out_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a scan when the block is idle |
| base_init | input | 16 | Initial base, which is also the first address |
| lim_init | input | 16 | Initial line limit |
| addr_step | input | 16 | Signed per-field step of the address stepper |
| base_step | input | 16 | Signed per-field step of the base slider |
| lim_step | input | 16 | Signed per-field step of the limit slider |
| addr_max | input | 8 | Step budget of one line |
| base_max | input | 8 | Step budget of the base slider (number of lines minus one) |
| lim_max | input | 8 | Step budget of the limit slider |
| base_stop | input | 16 | Base value that makes its line the final one |
| lim_stop | input | 16 | Limit value at which the limit slider holds |
| out_ready | input | 1 | Sink accepts the offered address |
| out_valid | output | 1 | An address is offered |
| out_addr | output | 16 | Offered address, y in 15:8, x in 7:0 |
| out_last | output | 1 | Offered address is the last of the scan |

## Verification
A fault in a step counter cannot be seen until the next line escape. It then shows as a line that is one address too long or too short, so a bench must run lines long enough to reach the budget. A corrupt base slider shows on the first address of the next line. A corrupt limit slider shows only when a line ends at a different address. For this reason the scenarios include lines that end by limit, lines that end by budget, and lines that end on a held limit. A stall fault shows within one cycle as a changed address while `out_ready` is low. The bench therefore compares every accepted address against an independent model, under both free-running and throttled `out_ready`.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // number of address fields (x and y)
  localparam int AXES = 2;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/scan_stepper.sv
module scan_stepper #(
  parameter int AW  = 8,
  parameter int NAX = 2,
  parameter int CW  = 8,
  localparam int VW = NAX * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [VW-1:0] ld_val,
  input  logic          adv,
  input  logic [VW-1:0] step,
  input  logic [CW-1:0] max_cnt,
  input  logic [VW-1:0] lim,
  output logic [VW-1:0] val,
  output logic          at_max,
  output logic          at_lim
);
  logic [VW-1:0] val_q;
  logic [VW-1:0] val_sum;
  logic [CW-1:0] cnt_q;

  // one wrapping adder per field; a signed step is a plain modulo add
  for (genvar g = 0; g < NAX; g++) begin : g_field
    assign val_sum[g*AW +: AW] = val_q[g*AW +: AW] + step[g*AW +: AW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (ld) begin
      val_q <= ld_val;
      cnt_q <= '0;
    end else if (adv) begin
      val_q <= val_sum;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign val    = val_q;
  assign at_max = (cnt_q == max_cnt);
  assign at_lim = (val_q == lim);
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ready,
  input  logic addr_at_lim,
  input  logic addr_at_max,
  input  logic base_at_lim,
  input  logic base_at_max,
  input  logic lim_at_lim,
  input  logic lim_at_max,
  output logic running,
  output logic init_ld,
  output logic addr_adv,
  output logic addr_ld,
  output logic base_adv,
  output logic lim_adv,
  output logic last
);
  seq_state_e state_q;
  logic fire, line_end, final_line, wrap, lim_hold;

  assign running    = (state_q == SEQ_RUN);
  assign fire       = running & ready;
  assign line_end   = addr_at_lim | addr_at_max;
  assign final_line = base_at_lim | base_at_max;
  assign lim_hold   = lim_at_lim | lim_at_max;

  assign init_ld  = (state_q == SEQ_IDLE) & start;
  assign wrap     = fire & line_end & ~final_line;
  assign addr_adv = fire & ~line_end;
  assign addr_ld  = init_ld | wrap;
  assign base_adv = wrap;
  assign lim_adv  = wrap & ~lim_hold;
  assign last     = running & line_end & final_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start) state_q <= SEQ_RUN;
        SEQ_RUN:  if (fire & line_end & final_line) state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import scan_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  localparam int VW = AXES * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] base_init,
  input  logic [VW-1:0] lim_init,
  input  logic [VW-1:0] addr_step,
  input  logic [VW-1:0] base_step,
  input  logic [VW-1:0] lim_step,
  input  logic [CW-1:0] addr_max,
  input  logic [CW-1:0] base_max,
  input  logic [CW-1:0] lim_max,
  input  logic [VW-1:0] base_stop,
  input  logic [VW-1:0] lim_stop,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [VW-1:0] out_addr,
  output logic          out_last
);
  logic          running, init_ld, addr_adv, addr_ld, base_adv, lim_adv, last;
  logic          addr_at_lim, addr_at_max;
  logic          base_at_lim, base_at_max;
  logic          lim_at_lim, lim_at_max;
  logic [VW-1:0] addr_val, base_val, lim_val;
  logic [VW-1:0] base_next, addr_src;

  // start of the next line: the base after its pending slide
  for (genvar g = 0; g < AXES; g++) begin : g_nbase
    assign base_next[g*AW +: AW] = base_val[g*AW +: AW] + base_step[g*AW +: AW];
  end

  assign addr_src = init_ld ? base_init : base_next;

  scan_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ready       (out_ready),
    .addr_at_lim (addr_at_lim),
    .addr_at_max (addr_at_max),
    .base_at_lim (base_at_lim),
    .base_at_max (base_at_max),
    .lim_at_lim  (lim_at_lim),
    .lim_at_max  (lim_at_max),
    .running     (running),
    .init_ld     (init_ld),
    .addr_adv    (addr_adv),
    .addr_ld     (addr_ld),
    .base_adv    (base_adv),
    .lim_adv     (lim_adv),
    .last        (last)
  );

  scan_stepper #(.AW(AW), .NAX(AXES), .CW(CW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (addr_ld),
    .ld_val  (addr_src),
    .adv     (addr_adv),
    .step    (addr_step),
    .max_cnt (addr_max),
    .lim     (lim_val),
    .val     (addr_val),
    .at_max  (addr_at_max),
    .at_lim  (addr_at_lim)
  );

  scan_stepper #(.AW(AW), .NAX(AXES), .CW(CW)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (init_ld),
    .ld_val  (base_init),
    .adv     (base_adv),
    .step    (base_step),
    .max_cnt (base_max),
    .lim     (base_stop),
    .val     (base_val),
    .at_max  (base_at_max),
    .at_lim  (base_at_lim)
  );

  scan_stepper #(.AW(AW), .NAX(AXES), .CW(CW)) u_lim (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (init_ld),
    .ld_val  (lim_init),
    .adv     (lim_adv),
    .step    (lim_step),
    .max_cnt (lim_max),
    .lim     (lim_stop),
    .val     (lim_val),
    .at_max  (lim_at_max),
    .at_lim  (lim_at_lim)
  );

  assign out_valid = running;
  assign out_addr  = addr_val;
  assign out_last  = last;
endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
  parameter int VW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [VW-1:0] base_init,
  input logic          out_ready,
  input logic          out_valid,
  input logic [VW-1:0] out_addr,
  input logic          out_last
);
  // R7
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R7
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_last));

  // R1
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && start |=> out_valid && (out_addr == $past(base_init)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && start |=> out_valid && $stable(out_addr));
endmodule

bind scan_addr_gen scan_addr_gen_chk #(.VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .base_init (base_init),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_addr  (out_addr),
  .out_last  (out_last)
);

// File: tb/scan_addr_gen_test.sv
module scan_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] base_init = '0, lim_init = '0;
  logic [15:0] addr_step = '0, base_step = '0, lim_step = '0;
  logic [7:0]  addr_max = '0, base_max = '0, lim_max = '0;
  logic [15:0] base_stop = '0, lim_stop = '0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [15:0] out_addr;
  logic        out_last;

  int checks = 0;
  int errors = 0;

  logic [15:0] exp_a [256];
  int          exp_n;
  logic [15:0] got_a [256];
  logic        got_l [256];
  int          got_n;

  always #10 clk = ~clk;  // 50 MHz

  scan_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_init(base_init), .lim_init(lim_init),
    .addr_step(addr_step), .base_step(base_step), .lim_step(lim_step),
    .addr_max(addr_max), .base_max(base_max), .lim_max(lim_max),
    .base_stop(base_stop), .lim_stop(lim_stop),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_addr(out_addr), .out_last(out_last)
  );

  function automatic logic [15:0] vadd(logic [15:0] a, logic [15:0] s);
    logic [7:0] x, y;
    x = a[7:0] + s[7:0];
    y = a[15:8] + s[15:8];
    return {y, x};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected sequence from the requirements
  task automatic model();
    logic [15:0] a, b, l;
    int ac, bc, lc;
    a = base_init; b = base_init; l = lim_init;
    ac = 0; bc = 0; lc = 0; exp_n = 0;
    while (exp_n < 256) begin
      exp_a[exp_n] = a;
      exp_n++;
      if (a == l || ac == int'(addr_max)) begin
        if (bc == int'(base_max) || b == base_stop) break;
        if (!(lc == int'(lim_max) || l == lim_stop)) begin
          l = vadd(l, lim_step); lc++;
        end
        b = vadd(b, base_step); bc++;
        a = b; ac = 0;
      end else begin
        a = vadd(a, addr_step); ac++;
      end
    end
  endtask

  task automatic run_scan(string req, bit throttle, bit poke);
    int cyc;
    bit done, stall;
    logic [15:0] stall_a;
    model();
    got_n = 0; done = 0; stall = 0; cyc = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R1", {31'd0, out_valid}, 32'd1, {req, " valid after start"});
    while (!done && cyc < 3000) begin
      start = (poke && cyc == 4) ? 1'b1 : 1'b0;
      if (stall) begin
        check("R8", {15'd0, out_valid, out_addr}, {16'd1, stall_a}, {req, " held during stall"});
        stall = 0;
      end
      out_ready = throttle ? (cyc % 3 != 1) : 1'b1;
      if (out_valid) begin
        if (out_ready) begin
          if (got_n < 256) begin
            got_a[got_n] = out_addr; got_l[got_n] = out_last; got_n++;
          end
          if (out_last) done = 1;
        end else begin
          stall = 1; stall_a = out_addr;
        end
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; out_ready = 1'b1;
    check("R7", {31'd0, out_valid}, 32'd0, {req, " idle after last"});
    check(req, got_n, exp_n, "address count");
    for (int i = 0; i < got_n && i < exp_n; i++) begin
      check(req, {16'd0, got_a[i]}, {16'd0, exp_a[i]}, $sformatf("address %0d", i));
      check("R7", {31'd0, got_l[i]}, {31'd0, (i == exp_n - 1)}, $sformatf("%s last flag %0d", req, i));
    end
  endtask

  task automatic set_video();
    base_init = 16'h0302; lim_init = 16'h0305;
    addr_step = 16'h0001; base_step = 16'h0100; lim_step = 16'h0100;
    addr_max = 8'd20; base_max = 8'd2; lim_max = 8'd10;
    base_stop = 16'hFFFF; lim_stop = 16'hFFFF;
  endtask

  task automatic t_reset();
    check("R1", {30'd0, out_valid, out_last}, 32'd0, "reset outputs");
  endtask

  task automatic t_video();  // R2 R3 R5 R7
    set_video();
    run_scan("R3", 1'b0, 1'b0);
    check("R5", {16'd0, got_a[4]}, 32'h0402, "second line start");
    check("R3", {16'd0, got_a[3]}, 32'h0305, "limit emitted");
  endtask

  task automatic t_budget();  // R4
    set_video();
    lim_init = 16'hC8C8; addr_max = 8'd2;
    run_scan("R4", 1'b0, 1'b0);
    check("R4", got_n, 9, "three lines of three");
  endtask

  task automatic t_shear();  // R5
    base_init = 16'h0000; lim_init = 16'h0003;
    addr_step = 16'h0001; base_step = 16'h0101; lim_step = 16'h0101;
    addr_max = 8'd30; base_max = 8'd3; lim_max = 8'd9;
    base_stop = 16'hFFFF; lim_stop = 16'hFFFF;
    run_scan("R5", 1'b0, 1'b0);
    check("R5", {16'd0, got_a[12]}, 32'h0303, "sheared line start");
  endtask

  task automatic t_reverse();  // R2 negative step
    base_init = 16'h000A; lim_init = 16'h0007;
    addr_step = 16'h00FF; base_step = 16'h0100; lim_step = 16'h0100;
    addr_max = 8'd20; base_max = 8'd1; lim_max = 8'd9;
    base_stop = 16'hFFFF; lim_stop = 16'hFFFF;
    run_scan("R2", 1'b0, 1'b0);
    check("R2", {16'd0, got_a[1]}, 32'h0009, "descending x");
  endtask

  task automatic t_lim_hold();  // R6
    set_video();
    lim_max = 8'd0; addr_max = 8'd10; base_max = 8'd1;
    run_scan("R6", 1'b0, 1'b0);
    check("R6", got_n, 15, "held limit by count");
    set_video();
    lim_max = 8'd9; addr_max = 8'd5; lim_stop = 16'h0405;
    run_scan("R6", 1'b0, 1'b0);
    check("R6", got_n, 14, "held limit by stop value");
  endtask

  task automatic t_base_stop();  // R7
    set_video();
    base_max = 8'd5; base_stop = 16'h0402;
    run_scan("R7", 1'b0, 1'b0);
    check("R7", got_n, 8, "base stop ends scan");
  endtask

  task automatic t_stall();  // R8
    set_video();
    run_scan("R8", 1'b1, 1'b0);
  endtask

  task automatic t_busy_start();  // R9
    set_video();
    run_scan("R9", 1'b0, 1'b1);
    check("R9", got_n, 12, "start while busy ignored");
  endtask

  task automatic t_single();  // R10
    base_init = 16'h1234; lim_init = 16'h0000;
    addr_step = '0; base_step = '0; lim_step = '0;
    addr_max = '0; base_max = '0; lim_max = '0;
    base_stop = 16'hFFFF; lim_stop = 16'hFFFF;
    run_scan("R10", 1'b0, 1'b0);
    check("R10", got_n, 1, "single address");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_video();
    t_budget();
    t_shear();
    t_reverse();
    t_lim_hold();
    t_base_stop();
    t_stall();
    t_busy_start();
    t_single();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule